// File: doc/BRIEF.md
# Packed SIMD Integer Multiply Unit

This block is one lane of a vector execution pipe. It multiplies the packed integer elements of a 64-bit operand word and returns a packed 64-bit result one cycle later. The element width is 8, 16, 32 or 64 bits, so a word holds 8, 4, 2 or 1 elements. Element i occupies bits [i*SEW +: SEW].

A vector arithmetic instruction word selects one of four products: the low half, or one of three high halves (signed by signed, unsigned by unsigned, and signed first operand by unsigned second operand). It also selects where the second operand comes from. It is either taken element by element from the vs1 word, or it is the scalar rs1 value cut to the element width and copied into every element.

When the instruction clears its mask-enable bit, elements whose mask bit is 0 keep their previous value, which is supplied on `old_vd_i`. An instruction that does not decode to one of the eight legal forms raises a one-cycle illegal flag and writes nothing.

Top module: `simd_mul_unit`

## Requirements
- R1: Only instructions whose bits [6:0] equal 7'b1010111 are legal. Any other value, presented with `valid_i`, gives `illegal_o`=1 and `valid_o`=0 in the next cycle.
- R2: Bits [31:26] select the operation: 100101 low half, 100111 signed×signed high, 100100 unsigned×unsigned high, 100110 signed×unsigned high. Bits [14:12] must be 010 or 110. Any other value in either field is illegal, as in R1, and `result_o` keeps its previous value.
- R3: The low-half operation returns the least significant SEW bits of each element product.
- R4: The signed×signed high operation returns bits [2*SEW-1:SEW] of the product of the two elements, both read as two's complement.
- R5: The unsigned×unsigned high operation returns bits [2*SEW-1:SEW] of the product of the two elements, both read as unsigned.
- R6: The signed×unsigned high operation returns bits [2*SEW-1:SEW] of the product of a two's-complement vs2 element and an unsigned second element, at every width including 64.
- R7: When bits [14:12] are 010, the second operand of element i is element i of `vs1_i`. When they are 110, it is `rs1_i[SEW-1:0]` for every element.
- R8: `sew_i` encodes the element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Element i uses mask bit `mask_i[i]`.
- R9: When instruction bit 25 is 0, each element whose mask bit is 0 takes its value from `old_vd_i`. When bit 25 is 1, every element is written.
- R10: The result, `valid_o` and `illegal_o` appear in the cycle after `valid_i`. Reset clears `valid_o` and `illegal_o`.
- R11: In a cycle without a legal `valid_i`, `result_o` holds its value and `valid_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| instr_i | input | 32 | Vector arithmetic instruction word |
| sew_i | input | 2 | Element width code |
| vs2_i | input | 64 | First (signed-capable) operand word |
| vs1_i | input | 64 | Second operand word, vector form |
| rs1_i | input | 64 | Scalar second operand, vector-scalar form |
| mask_i | input | 8 | Per-element mask bits |
| old_vd_i | input | 64 | Prior destination value for masked-off elements |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Illegal instruction flag |
| result_o | output | 64 | Packed result word |

## Verification
Each unit has a single register stage, so a fault in the decode, in the correction terms of the high-half products or in the byte-merge select shows at `result_o`, `valid_o` or `illegal_o` in the very next cycle. Wrong decoding appears as a missing or spurious illegal flag. A bad sign correction shows as a high half off by one operand, and is most visible with the most negative value and all-ones operands. A bad merge select shows as bytes taken from the wrong source at element boundaries. Back-to-back operations with idle cycles between them expose a result register that changes when it should hold.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  localparam logic [6:0] OPC_VARITH = 7'b1010111;
  localparam logic [5:0] F6_LO  = 6'b100101;
  localparam logic [5:0] F6_HSS = 6'b100111;
  localparam logic [5:0] F6_HUU = 6'b100100;
  localparam logic [5:0] F6_HSU = 6'b100110;
  localparam logic [2:0] F3_VV  = 3'b010;
  localparam logic [2:0] F3_VX  = 3'b110;

  typedef enum logic [1:0] {
    OP_LO  = 2'd0,
    OP_HSS = 2'd1,
    OP_HUU = 2'd2,
    OP_HSU = 2'd3
  } mul_op_e;

  typedef struct packed {
    logic    legal;
    mul_op_e op;
    logic    use_scalar;
    logic    all_on;
  } dec_t;
endpackage

// File: rtl/simd_mul_decode.sv
module simd_mul_decode
  import simd_mul_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [5:0] f6;
  logic [2:0] f3;
  logic       op_ok, src_ok, opc_ok;
  mul_op_e    op;

  assign f6 = instr_i[31:26];
  assign f3 = instr_i[14:12];

  always_comb begin
    op_ok = 1'b1;
    op    = OP_LO;
    unique case (f6)
      F6_LO:   op = OP_LO;
      F6_HSS:  op = OP_HSS;
      F6_HUU:  op = OP_HUU;
      F6_HSU:  op = OP_HSU;
      default: op_ok = 1'b0;
    endcase
  end

  assign src_ok = (f3 == F3_VV) || (f3 == F3_VX);
  assign opc_ok = (instr_i[6:0] == OPC_VARITH);

  assign dec_o.legal      = op_ok & src_ok & opc_ok;
  assign dec_o.op         = op;
  assign dec_o.use_scalar = f3[2];
  assign dec_o.all_on     = instr_i[25];
endmodule

// File: rtl/simd_mul_elem.sv
module simd_mul_elem
  import simd_mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  mul_op_e      op_i,
  output logic [W-1:0] res_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  hi_raw, corr_a, corr_b, hi;
  logic          a_signed, b_signed;

  // one unsigned array per width; signed forms fixed up on the high half
  assign prod     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign hi_raw   = prod[PW-1:W];
  assign a_signed = (op_i == OP_HSS) || (op_i == OP_HSU);
  assign b_signed = (op_i == OP_HSS);
  assign corr_a   = (a_signed && a_i[W-1]) ? b_i : '0;
  assign corr_b   = (b_signed && b_i[W-1]) ? a_i : '0;
  assign hi       = hi_raw - corr_a - corr_b;
  assign res_o    = (op_i == OP_LO) ? prod[W-1:0] : hi;

  always_comb begin
    // R3
    if (b_i == '0) zero_operand_chk: assert (res_o == '0);
  end
endmodule

// File: rtl/simd_mul_slice.sv
module simd_mul_slice
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ELEM_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  mul_op_e           op_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int N_ELEM = DATA_W / ELEM_W;

  for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
    simd_mul_elem #(.W(ELEM_W)) elem_i (
      .a_i  (a_i[g*ELEM_W +: ELEM_W]),
      .b_i  (b_i[g*ELEM_W +: ELEM_W]),
      .op_i (op_i),
      .res_o(res_o[g*ELEM_W +: ELEM_W])
    );
  end
endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [1:0]        sew_i,
  input  logic [DATA_W-1:0] vs2_i,
  input  logic [DATA_W-1:0] vs1_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W/8-1:0] mask_i,
  input  logic [DATA_W-1:0] old_vd_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int N_BYTE  = DATA_W / 8;
  localparam int NUM_SEW = $clog2(N_BYTE) + 1;
  localparam int IDX_W   = (N_BYTE > 1) ? $clog2(N_BYTE) : 1;

  dec_t              dec;
  logic [DATA_W-1:0] bcast, b_sel, prod_sel, merged;
  logic [DATA_W-1:0] res_w [NUM_SEW];
  logic              valid_q, illegal_q;
  logic [DATA_W-1:0] result_q;

  simd_mul_decode dec_i (
    .instr_i(instr_i),
    .dec_o  (dec)
  );

  always_comb begin
    bcast = rs1_i;
    for (int k = 0; k < NUM_SEW; k++) begin
      if (int'(sew_i) == k) begin
        for (int j = 0; j < DATA_W; j++) bcast[j] = rs1_i[j % (8 << k)];
      end
    end
  end

  assign b_sel = dec.use_scalar ? bcast : vs1_i;

  for (genvar k = 0; k < NUM_SEW; k++) begin : g_width
    simd_mul_slice #(.DATA_W(DATA_W), .ELEM_W(8 << k)) slice_i (
      .a_i  (vs2_i),
      .b_i  (b_sel),
      .op_i (dec.op),
      .res_o(res_w[k])
    );
  end

  always_comb begin
    prod_sel = res_w[0];
    for (int k = 1; k < NUM_SEW; k++) begin
      if (int'(sew_i) == k) prod_sel = res_w[k];
    end
  end

  for (genvar j = 0; j < N_BYTE; j++) begin : g_byte
    logic [IDX_W-1:0] eidx;
    logic             take_new;
    assign eidx     = IDX_W'(j) >> sew_i;
    assign take_new = dec.all_on | mask_i[eidx];
    assign merged[j*8 +: 8] = take_new ? prod_sel[j*8 +: 8] : old_vd_i[j*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      result_q  <= '0;
    end else begin
      valid_q   <= valid_i & dec.legal;
      illegal_q <= valid_i & ~dec.legal;
      if (valid_i && dec.legal) result_q <= merged;
    end
  end

  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;
  assign result_o  = result_q;

  // R1
  bad_opcode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[6:0] != OPC_VARITH) |=> illegal_o && !valid_o);

  // R2
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o));

  // R9
  masked_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.legal && !instr_i[25] && (mask_i == '0) |=> result_o == $past(old_vd_i));

  // R10
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.legal |=> valid_o);

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && dec.legal) |=> $stable(result_o) && !valid_o);
endmodule

// File: tb/simd_mul_unit_tb_top.sv
`timescale 1ns/1ps
module simd_mul_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [1:0]  sew_i = '0;
  logic [63:0] vs2_i = '0, vs1_i = '0, rs1_i = '0, old_i = '0;
  logic [7:0]  mask_i = '0;
  logic        valid_o, illegal_o;
  logic [63:0] result_o;

  always #2 clk = ~clk;

  simd_mul_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .sew_i(sew_i), .vs2_i(vs2_i), .vs1_i(vs1_i), .rs1_i(rs1_i),
    .mask_i(mask_i), .old_vd_i(old_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  typedef struct packed { logic v; logic il; logic [63:0] r; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_fail = 0;
  logic  [63:0] last_res = '0;
  logic  mon_on = 1'b0;

  localparam logic [5:0] F6 [4] = '{6'b100101, 6'b100111, 6'b100100, 6'b100110};

  function automatic logic [31:0] mk(logic [5:0] f6, logic vm, logic [2:0] f3, logic [6:0] opc);
    return {f6, vm, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [63:0] ref_elem(logic [63:0] a, logic [63:0] b, int op, int w);
    logic [63:0] m;
    logic signed [129:0] ea, eb, p, sh;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    ea = $signed({66'd0, a & m});
    eb = $signed({66'd0, b & m});
    if ((op == 1 || op == 3) && a[w-1]) ea = ea - (130'sd1 <<< w);
    if (op == 1 && b[w-1]) eb = eb - (130'sd1 <<< w);
    p  = ea * eb;
    sh = p >>> w;
    return (op == 0) ? (p[63:0] & m) : (sh[63:0] & m);
  endfunction

  task automatic issue(int op, logic vx, logic vm, int sew, logic [63:0] a,
                       logic [63:0] b, logic [7:0] msk, logic [63:0] old, string tag);
    int w;
    logic [63:0] nv, rv;
    exp_t e;
    w  = 8 << sew;
    nv = '0;
    for (int i = 0; i < 64 / w; i++) begin
      logic [63:0] bb;
      bb = vx ? b : (b >> (i * w));
      nv = nv | (ref_elem(a >> (i * w), bb, op, w) << (i * w));
    end
    for (int k = 0; k < 64; k++) rv[k] = (vm || msk[k / w]) ? nv[k] : old[k];
    @(negedge clk);
    valid_i = 1'b1;
    instr_i = mk(F6[op], vm, vx ? 3'b110 : 3'b010, 7'b1010111);
    sew_i = 2'(sew); vs2_i = a; old_i = old; mask_i = msk;
    if (vx) begin rs1_i = b; vs1_i = ~b; end
    else begin vs1_i = b; rs1_i = ~b; end
    e = '{1'b1, 1'b0, rv};
    last_res = rv;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic issue_bad(logic [31:0] ins, string tag);
    @(negedge clk);
    valid_i = 1'b1; instr_i = ins; vs2_i = 64'h1234; vs1_i = 64'h5678;
    mask_i = 8'hff;
    exp_q.push_back('{1'b0, 1'b1, last_res}); tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0; vs2_i = ~vs2_i; instr_i = mk(F6[0], 1'b1, 3'b010, 7'b1010111);
    // R11 idle cycle with legal-looking instruction but no strobe
    exp_q.push_back('{1'b0, 1'b0, last_res}); tag_q.push_back("R11");
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_on && exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (valid_o !== e.v || illegal_o !== e.il || result_o !== e.r) begin
        n_fail++;
        $display("FAIL %s: got v=%0b il=%0b r=%h expected v=%0b il=%0b r=%h",
                 t, valid_o, illegal_o, result_o, e.v, e.il, e.r);
      end
    end
  end

  function automatic logic [63:0] min_word(int sew);
    logic [63:0] r;
    int w;
    w = 8 << sew;
    r = '0;
    for (int i = 0; i < 64 / w; i++) r[i * w + w - 1] = 1'b1;
    return r;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] pats [5];
    repeat (3) @(negedge clk);
    // R10 reset state
    n_chk++;
    if (valid_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: got v=%0b il=%0b expected v=0 il=0", valid_o, illegal_o);
    end
    rst_n = 1'b1;
    mon_on = 1'b1;
    for (int s = 0; s < 4; s++) begin
      pats[0] = min_word(s);
      pats[1] = '1;
      pats[2] = '0;
      pats[3] = 64'h0123_4567_89ab_cdef;
      pats[4] = 64'hfedc_ba98_7f65_8310;
      for (int op = 0; op < 4; op++) begin
        for (int x = 0; x < 5; x++) begin
          for (int y = 0; y < 5; y++) begin
            case (op)
              0: issue(op, 1'b0, 1'b1, s, pats[x], pats[y], 8'h00, 64'h0, "R3");
              1: issue(op, 1'b0, 1'b1, s, pats[x], pats[y], 8'h00, 64'h0, "R4");
              2: issue(op, 1'b0, 1'b1, s, pats[x], pats[y], 8'h00, 64'h0, "R5");
              default: issue(op, 1'b0, 1'b1, s, pats[x], pats[y], 8'h00, 64'h0, "R6");
            endcase
            // R7 scalar broadcast, upper rs1 bits must be dropped
            issue(op, 1'b1, 1'b1, s, pats[x], pats[(y + 3) % 5], 8'h00, 64'h0, "R7");
          end
        end
        idle();
      end
      // R8 R9 per-element masking at each width
      issue(1, 1'b0, 1'b0, s, pats[0], pats[1], 8'b1010_0101, 64'h5a5a_c3c3_0ff0_9669, "R8 R9");
      issue(3, 1'b1, 1'b0, s, pats[4], pats[3], 8'b0101_1010, 64'h1111_2222_3333_4444, "R8 R9");
      issue(0, 1'b0, 1'b0, s, pats[3], pats[4], 8'h00, 64'hdead_beef_cafe_f00d, "R9");
      issue(2, 1'b0, 1'b1, s, pats[1], pats[1], 8'h00, 64'hdead_beef_cafe_f00d, "R9");
    end
    issue_bad(mk(6'b100101, 1'b1, 3'b010, 7'b1010011), "R1");
    idle();
    issue_bad(mk(6'b100000, 1'b1, 3'b010, 7'b1010111), "R2");
    issue_bad(mk(6'b100111, 1'b1, 3'b000, 7'b1010111), "R2");
    issue_bad(mk(6'b100110, 1'b1, 3'b011, 7'b1010111), "R2");
    issue(1, 1'b0, 1'b1, 3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h0, 64'h0, "R10");
    issue(3, 1'b1, 1'b1, 3, 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 8'h0, 64'h0, "R6");
    repeat (3) idle();
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule